// File: doc/BRIEF.md
# Video DMA Mode Controller

This block sequences the three kinds of video-memory DMA: fill, copy, and transfer from the external bus into video memory. It takes the kind from the top two bits of the DMA source-high register and decides when a DMA begins to run and when it ends. The decision depends on control-port commands, data-port writes and the drained state of the write FIFO. It also loads a countdown with the shortest time the DMA can take. That time depends on the length, the horizontal cell mode and whether each word needs two byte writes.

A non-fill DMA starts on the command that requests it. A fill only arms on that command. The data word that follows supplies the fill value, and the run flag rises once the FIFO has drained that word. While a copy runs, an external slot with no FIFO work writes the byte fetched earlier to the current address with bit 0 inverted, provided a read has been fetched. A transfer-unit strobe decrements the length counter. The last unit ends the run and raises a done pulse.

Top module: `dma_mode_top`

## Requirements
- R1: The kind is taken from srcHigh[7:6] when the command is accepted: 2'b10 is fill, 2'b11 is copy, and 2'b00 or 2'b01 is transfer.
- R2: When cmdDone is high with cmdCode[5]=1 and the kind is not fill, dmaRun is high from the next clock edge.
- R3: For a fill, the command leaves dmaRun low. After the next dataWr, dmaRun rises on the edge after fifoEmpty is sampled high. A dataWr during a running fill drops dmaRun until fifoEmpty is high again.
- R4: dataReject is high, combinationally, exactly when dataWr is high while dmaRun is high and the kind is not fill. A rejected write changes no state.
- R5: On an accepted command, busyCount loads length × 16 when wide40=1, or length × 20 otherwise. The value is doubled for a copy, and for a VRAM target (cmdCode[3:0]=4'b0001) when vram128=0.
- R6: busyCount decrements by one per clock until it reaches 0, then holds at 0.
- R7: In the cycle after extSlot and readFetched are both high during a running copy, copyWrEn pulses for one cycle, with copyWrAddr = curAddr ^ 1 and copyWrData = fetchByte. Outside a running copy, or with readFetched low, copyWrEn stays low.
- R8: Each stepUnit during a run consumes one unit. On the last unit, dmaRun falls and dmaDone is high for exactly one cycle.
- R9: A dmaLen of 0 stands for 65536 units, for both the run length and the busy time.
- R10: Reset clears the run and the armed state and sets busyCount to 0. A command with cmdCode[5]=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdDone | input | 1 | Control-port command completed |
| cmdCode | input | 6 | Command code; bit 5 requests DMA, bits 3:0 select target |
| srcHigh | input | 8 | DMA source-high register; bits 7:6 give the kind |
| dmaLen | input | 16 | DMA length in units, 0 means 65536 |
| wide40 | input | 1 | 40-cell horizontal mode |
| vram128 | input | 1 | Word-wide (128K) VRAM mode |
| dataWr | input | 1 | Data-port write strobe |
| fifoEmpty | input | 1 | Write FIFO drained |
| stepUnit | input | 1 | One DMA unit transferred |
| extSlot | input | 1 | External slot with no FIFO work |
| readFetched | input | 1 | Copy read byte is available |
| fetchByte | input | 8 | Byte fetched for copy |
| curAddr | input | 17 | Current DMA destination address |
| dmaRun | output | 1 | DMA running |
| dmaDone | output | 1 | One-cycle pulse at DMA end |
| dataReject | output | 1 | Data-port write refused |
| copyWrEn | output | 1 | Copy byte write strobe |
| copyWrAddr | output | 17 | Copy byte write address |
| copyWrData | output | 8 | Copy byte write data |
| busyCount | output | 23 | Remaining minimum completion time |

## Verification
The assertions assume that srcHigh keeps the kind stable for one cycle after an accepted command. They also assume that curAddr does not change in the cycle in which a copy write is requested. Neither property is checked at the ports. The bench changes srcHigh, cmdCode and the mode bits only between commands. It drives curAddr and fetchByte together with extSlot and holds them until the write is sampled. It asserts stepUnit only while a DMA runs, so every unit it issues is one the counter expects.

// File: rtl/dma_mode_pkg.sv
package dma_mode_pkg;
  typedef enum logic [1:0] {
    KIND_XFER = 2'd0,
    KIND_FILL = 2'd1,
    KIND_COPY = 2'd2
  } dmaKind_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ARMED    = 2'd1,
    ST_FILLWAIT = 2'd2,
    ST_RUN      = 2'd3
  } dmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLen;
    logic stepLen;
    logic copyFire;
  } ctrlStrobe_t;

  function automatic dmaKind_t decodeKind(input logic [1:0] typeBits);
    case (typeBits)
      2'b10:   return KIND_FILL;
      2'b11:   return KIND_COPY;
      default: return KIND_XFER;
    endcase
  endfunction
endpackage

// File: rtl/dma_mode_ctrl.sv
module dma_mode_ctrl
  import dma_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startCmd,
  input  dmaKind_t    kindIn,
  input  logic        dataWr,
  input  logic        fifoEmpty,
  input  logic        stepUnit,
  input  logic        extSlot,
  input  logic        readFetched,
  input  logic        lenAtOne,
  output logic        dmaRun,
  output logic        dmaDone,
  output logic        dataReject,
  output ctrlStrobe_t strobe
);
  dmaState_t state, stateNxt;
  dmaKind_t  kind;
  logic      doneNxt;

  always_comb begin
    stateNxt       = state;
    doneNxt        = 1'b0;
    strobe.loadLen = 1'b0;
    strobe.stepLen = 1'b0;
    if (startCmd) begin
      strobe.loadLen = 1'b1;
      stateNxt = (kindIn == KIND_FILL) ? ST_ARMED : ST_RUN;
    end else begin
      case (state)
        ST_ARMED:    if (dataWr) stateNxt = ST_FILLWAIT;
        ST_FILLWAIT: if (fifoEmpty) stateNxt = ST_RUN;
        ST_RUN: begin
          if (kind == KIND_FILL && dataWr) begin
            stateNxt = ST_FILLWAIT;
          end else if (stepUnit) begin
            strobe.stepLen = 1'b1;
            if (lenAtOne) begin
              stateNxt = ST_IDLE;
              doneNxt  = 1'b1;
            end
          end
        end
        default: stateNxt = state;
      endcase
    end
    strobe.copyFire = (state == ST_RUN) && (kind == KIND_COPY) && extSlot && readFetched;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= KIND_XFER;
      dmaDone <= 1'b0;
    end else begin
      state   <= stateNxt;
      dmaDone <= doneNxt;
      if (startCmd) kind <= kindIn;
    end
  end

  assign dmaRun     = (state == ST_RUN);
  assign dataReject = dataWr && (state == ST_RUN) && (kind != KIND_FILL);
endmodule

// File: rtl/dma_mode_dp.sv
module dma_mode_dp
  import dma_mode_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int ADDR_W   = 17,
  parameter int BYTE_W   = 8,
  parameter int FAST_CLK = 16,
  parameter int SLOW_CLK = 20,
  parameter int BUSY_W   = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LEN_W-1:0]  lenIn,
  input  dmaKind_t          kindIn,
  input  logic              tgtVram,
  input  logic              wide40,
  input  logic              vram128,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [BYTE_W-1:0] fetchByte,
  output logic              lenAtOne,
  output logic [BUSY_W-1:0] busyCount,
  output logic              copyWrEn,
  output logic [ADDR_W-1:0] copyWrAddr,
  output logic [BYTE_W-1:0] copyWrData
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0]  lenCnt, lenLoad;
  logic [BUSY_W-1:0] unitClk, busyBase, busyLoad;
  logic              dblRate;

  always_comb begin
    lenLoad  = (lenIn == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, lenIn};
    unitClk  = wide40 ? BUSY_W'(FAST_CLK) : BUSY_W'(SLOW_CLK);
    busyBase = BUSY_W'(lenLoad) * unitClk;
    dblRate  = (kindIn == KIND_COPY) || (tgtVram && !vram128);
    busyLoad = dblRate ? (busyBase << 1) : busyBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenCnt     <= '0;
      busyCount  <= '0;
      copyWrEn   <= 1'b0;
      copyWrAddr <= '0;
      copyWrData <= '0;
    end else begin
      if (strobe.loadLen)      lenCnt <= lenLoad;
      else if (strobe.stepLen) lenCnt <= lenCnt - 1'b1;
      if (strobe.loadLen)        busyCount <= busyLoad;
      else if (busyCount != '0)  busyCount <= busyCount - 1'b1;
      copyWrEn <= strobe.copyFire;
      if (strobe.copyFire) begin
        copyWrAddr <= curAddr ^ ADDR_W'(1);
        copyWrData <= fetchByte;
      end
    end
  end

  assign lenAtOne = (lenCnt == CNT_W'(1));
endmodule

// File: rtl/dma_mode_top.sv
module dma_mode_top
  import dma_mode_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int ADDR_W   = 17,
  parameter int BYTE_W   = 8,
  parameter int CODE_W   = 6,
  parameter int FAST_CLK = 16,
  parameter int SLOW_CLK = 20,
  parameter int BUSY_W   = LEN_W + 1 + $clog2(SLOW_CLK) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdDone,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic [7:0]        srcHigh,
  input  logic [LEN_W-1:0]  dmaLen,
  input  logic              wide40,
  input  logic              vram128,
  input  logic              dataWr,
  input  logic              fifoEmpty,
  input  logic              stepUnit,
  input  logic              extSlot,
  input  logic              readFetched,
  input  logic [BYTE_W-1:0] fetchByte,
  input  logic [ADDR_W-1:0] curAddr,
  output logic              dmaRun,
  output logic              dmaDone,
  output logic              dataReject,
  output logic              copyWrEn,
  output logic [ADDR_W-1:0] copyWrAddr,
  output logic [BYTE_W-1:0] copyWrData,
  output logic [BUSY_W-1:0] busyCount
);
  localparam int DMA_BIT = 5;

  ctrlStrobe_t strobe;
  dmaKind_t    kindIn;
  logic        startCmd, tgtVram, lenAtOne;

  assign startCmd = cmdDone && cmdCode[DMA_BIT];
  assign kindIn   = decodeKind(srcHigh[7:6]);
  assign tgtVram  = (cmdCode[3:0] == 4'b0001);

  dma_mode_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .kindIn(kindIn),
    .dataWr(dataWr), .fifoEmpty(fifoEmpty), .stepUnit(stepUnit),
    .extSlot(extSlot), .readFetched(readFetched), .lenAtOne(lenAtOne),
    .dmaRun(dmaRun), .dmaDone(dmaDone), .dataReject(dataReject), .strobe(strobe)
  );

  dma_mode_dp #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
    .FAST_CLK(FAST_CLK), .SLOW_CLK(SLOW_CLK), .BUSY_W(BUSY_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lenIn(dmaLen), .kindIn(kindIn),
    .tgtVram(tgtVram), .wide40(wide40), .vram128(vram128), .curAddr(curAddr),
    .fetchByte(fetchByte), .lenAtOne(lenAtOne), .busyCount(busyCount),
    .copyWrEn(copyWrEn), .copyWrAddr(copyWrAddr), .copyWrData(copyWrData)
  );
endmodule

// File: rtl/dma_mode_chk.sv
module dma_mode_chk #(
  parameter int ADDR_W = 17,
  parameter int BUSY_W = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdDone,
  input logic [5:0]        cmdCode,
  input logic [7:0]        srcHigh,
  input logic [ADDR_W-1:0] curAddr,
  input logic              dmaRun,
  input logic              dmaDone,
  input logic              dataReject,
  input logic              copyWrEn,
  input logic [ADDR_W-1:0] copyWrAddr,
  input logic [BUSY_W-1:0] busyCount
);
  logic startSeen;
  assign startSeen = cmdDone && cmdCode[5];

  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen && srcHigh[7:6] != 2'b10) |=> dmaRun);

  assert_fill_waits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen && srcHigh[7:6] == 2'b10) |=> !dmaRun);

  assert_reject_running_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataReject |-> dmaRun);

  assert_busy_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busyCount != '0 && !startSeen) |=> busyCount == $past(busyCount) - 1'b1);

  assert_copy_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    copyWrEn |-> copyWrAddr == ($past(curAddr) ^ ADDR_W'(1)));

  assert_done_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |-> !dmaRun);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> !dmaDone);
endmodule

bind dma_mode_top dma_mode_chk #(.ADDR_W(ADDR_W), .BUSY_W(BUSY_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdDone(cmdDone), .cmdCode(cmdCode), .srcHigh(srcHigh),
  .curAddr(curAddr), .dmaRun(dmaRun), .dmaDone(dmaDone), .dataReject(dataReject),
  .copyWrEn(copyWrEn), .copyWrAddr(copyWrAddr), .busyCount(busyCount)
);

// File: tb/dma_mode_top_test.sv
`timescale 1ns/1ps
module dma_mode_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdDone = 1'b0;
  logic [5:0]  cmdCode = '0;
  logic [7:0]  srcHigh = '0;
  logic [15:0] dmaLen = '0;
  logic        wide40 = 1'b0, vram128 = 1'b0, dataWr = 1'b0, fifoEmpty = 1'b0;
  logic        stepUnit = 1'b0, extSlot = 1'b0, readFetched = 1'b0;
  logic [7:0]  fetchByte = '0;
  logic [16:0] curAddr = '0;
  logic        dmaRun, dmaDone, dataReject, copyWrEn;
  logic [16:0] copyWrAddr;
  logic [7:0]  copyWrData;
  logic [22:0] busyCount;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_mode_top uut (
    .clk(clk), .rstN(rstN), .cmdDone(cmdDone), .cmdCode(cmdCode), .srcHigh(srcHigh),
    .dmaLen(dmaLen), .wide40(wide40), .vram128(vram128), .dataWr(dataWr),
    .fifoEmpty(fifoEmpty), .stepUnit(stepUnit), .extSlot(extSlot),
    .readFetched(readFetched), .fetchByte(fetchByte), .curAddr(curAddr),
    .dmaRun(dmaRun), .dmaDone(dmaDone), .dataReject(dataReject), .copyWrEn(copyWrEn),
    .copyWrAddr(copyWrAddr), .copyWrData(copyWrData), .busyCount(busyCount)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic issue(input logic [7:0] sh, input logic [5:0] cc, input logic [15:0] len,
                       input logic w40, input logic v128);
    srcHigh = sh; cmdCode = cc; dmaLen = len; wide40 = w40; vram128 = v128;
    cmdDone = 1'b1;
    tick();
    cmdDone = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R10 run after reset", dmaRun, 0);
    chk("R10 busy after reset", busyCount, 0);
    chk("R10 done after reset", dmaDone, 0);
    chk("R10 copy write after reset", copyWrEn, 0);
    issue(8'h00, 6'h01, 16'd7, 1'b1, 1'b0);
    chk("R10 command without DMA bit run", dmaRun, 0);
    chk("R10 command without DMA bit busy", busyCount, 0);
  endtask

  task automatic testTransfer();
    issue(8'h00, 6'h21, 16'd3, 1'b1, 1'b0);
    chk("R2 transfer starts", dmaRun, 1);
    chk("R5 busy 3*16*2", busyCount, 96);
    dataWr = 1'b1; #1;
    chk("R4 reject during transfer", dataReject, 1);
    tick(); dataWr = 1'b0;
    chk("R4 rejected write keeps run", dmaRun, 1);
    extSlot = 1'b1; readFetched = 1'b1; tick(); extSlot = 1'b0; readFetched = 1'b0;
    tick();
    chk("R7 no copy write in transfer", copyWrEn, 0);
    stepUnit = 1'b1;
    tick(); tick();
    chk("R8 run before last unit", dmaRun, 1);
    tick(); stepUnit = 1'b0;
    chk("R8 run falls at last unit", dmaRun, 0);
    chk("R8 done pulse", dmaDone, 1);
    tick();
    chk("R8 done one cycle", dmaDone, 0);
  endtask

  task automatic testFill();
    issue(8'h80, 6'h21, 16'd2, 1'b0, 1'b1);
    chk("R3 fill only arms", dmaRun, 0);
    chk("R5 busy 2*20", busyCount, 40);
    for (int i = 0; i < 10; i++) tick();
    chk("R6 busy counts down", busyCount, 30);
    dataWr = 1'b1; fifoEmpty = 1'b0; #1;
    chk("R4 no reject when armed fill", dataReject, 0);
    tick(); dataWr = 1'b0;
    chk("R3 run low after fill data", dmaRun, 0);
    tick(); tick();
    chk("R3 run low while FIFO busy", dmaRun, 0);
    fifoEmpty = 1'b1; tick();
    chk("R3 run after FIFO drains", dmaRun, 1);
    dataWr = 1'b1; fifoEmpty = 1'b0; #1;
    chk("R4 no reject during fill run", dataReject, 0);
    tick(); dataWr = 1'b0;
    chk("R3 fill data drops run", dmaRun, 0);
    fifoEmpty = 1'b1; tick();
    chk("R3 run resumes", dmaRun, 1);
    stepUnit = 1'b1; tick();
    chk("R8 fill still running", dmaRun, 1);
    tick(); stepUnit = 1'b0;
    chk("R8 fill ends", dmaRun, 0);
    chk("R8 fill done", dmaDone, 1);
    fifoEmpty = 1'b0;
  endtask

  task automatic testCopy();
    issue(8'hC0, 6'h21, 16'd1, 1'b1, 1'b1);
    chk("R1 copy kind starts", dmaRun, 1);
    chk("R5 copy doubled 1*16*2", busyCount, 32);
    extSlot = 1'b1; readFetched = 1'b0; tick();
    chk("R7 no write without fetch", copyWrEn, 0);
    readFetched = 1'b1; curAddr = 17'h01234; fetchByte = 8'hAB; tick();
    chk("R7 copy write strobe", copyWrEn, 1);
    chk("R7 copy address xor 1", copyWrAddr, 17'h01235);
    chk("R7 copy data", copyWrData, 8'hAB);
    curAddr = 17'h0F001; fetchByte = 8'h5C; tick();
    chk("R7 odd address", copyWrAddr, 17'h0F000);
    chk("R7 second data", copyWrData, 8'h5C);
    extSlot = 1'b0; readFetched = 1'b0; tick();
    chk("R7 strobe ends", copyWrEn, 0);
    dataWr = 1'b1; #1;
    chk("R4 reject during copy", dataReject, 1);
    dataWr = 1'b0;
    stepUnit = 1'b1; tick(); stepUnit = 1'b0;
    chk("R8 copy ends", dmaRun, 0);
  endtask

  task automatic testDoubling();
    issue(8'h40, 6'h21, 16'd5, 1'b0, 1'b0);
    chk("R1 type 01 is transfer", dmaRun, 1);
    chk("R5 byte VRAM doubled 5*20*2", busyCount, 200);
    issue(8'h00, 6'h25, 16'd5, 1'b0, 1'b0);
    chk("R5 non-VRAM not doubled", busyCount, 100);
    issue(8'h00, 6'h21, 16'd5, 1'b1, 1'b1);
    chk("R5 word VRAM not doubled", busyCount, 80);
    doReset();
    issue(8'h80, 6'h21, 16'd1, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) tick();
    chk("R6 busy holds at zero", busyCount, 0);
    doReset();
    dataWr = 1'b1; tick(); dataWr = 1'b0;
    fifoEmpty = 1'b1; tick(); tick();
    chk("R10 reset clears armed fill", dmaRun, 0);
    fifoEmpty = 1'b0;
  endtask

  task automatic testZeroLen();
    issue(8'h00, 6'h23, 16'd0, 1'b0, 1'b0);
    chk("R9 busy for 65536 units", busyCount, 1310720);
    stepUnit = 1'b1;
    for (int i = 0; i < 65535; i++) tick();
    chk("R9 still running after 65535", dmaRun, 1);
    tick(); stepUnit = 1'b0;
    chk("R9 ends at 65536", dmaRun, 0);
    chk("R9 done", dmaDone, 1);
  endtask

  initial begin
    testReset();
    testTransfer();
    testFill();
    testCopy();
    testDoubling();
    testZeroLen();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule